// File: doc/BRIEF.md
# Vectored Prioritized Interrupt Controller

This block gathers 64 level-sensitive interrupt sources and presents them to a processor as two active-high request lines: a normal request and a fast request. Each source carries an enable bit, a routing bit that selects the normal or the fast line, a software force bit and a 4-bit priority. All of this state sits behind a simple 32-bit register bus with an address, a write strobe, write data and combinational read data.

Software can enable or disable one source by writing that source's number to a dedicated register, without a read-modify-write of the enable word. Normal requests pass through a priority threshold. A global block bit can shut all normal requests off. Two vector registers report the winning source. For the normal line the winner is the source with the highest priority, and a tie goes to the higher source number. For the fast line the winner is the highest-numbered pending source. A handler reads the vector register to learn which source to service.

Top module: `prio_intc`

## Requirements
- R1: After reset, control (0x00) reads 0, the mask register (0x04) reads 0x1F, and all enable, type, force and priority registers read 0. Both request outputs are low and both vector registers read 0xFFFFFFFF.
- R2: Writing a source number N (0..63) to 0x08 sets only enable bit N, and writing it to 0x0C clears only bit N. A value with any bit above bit 5 set leaves every enable bit unchanged. Both registers read 0.
- R3: The enable (0x10 high, 0x14 low), type (0x18 high, 0x1C low) and force (0x50 high, 0x54 low) registers are read/write. Each low word holds sources 31..0 and each high word holds sources 63..32, one bit per source at bit position (N mod 32).
- R4: The priority of source N is the 4-bit field at bits (N mod 8)*4 of the register for group g = N/8. That register sits at offset 0x20 + 4*(7-g), so group 7 is at 0x20 and group 0 is at 0x3C.
- R5: A source's effective request is its input OR its force bit. Raw inputs read at 0x48/0x4C. Normal pending (0x58/0x5C) is effective AND enable AND NOT type. Fast pending (0x60/0x64) is effective AND enable AND type. The high word is listed first in each pair.
- R6: The mask register at 0x04 keeps the low 5 bits written, and its bits 31:5 read 0. While mask bit 4 is 1, no normal source qualifies. While bit 4 is 0, a normal pending source qualifies only if its priority is at least mask bits 3:0.
- R7: The normal vector at 0x40 reads {16-bit source number, 16-bit priority} for the qualifying source with the highest priority, with ties going to the higher source number. It reads 0xFFFFFFFF when no source qualifies.
- R8: The fast vector at 0x44 reads the highest-numbered fast pending source in bits 31:16, with bits 15:0 at 0. It reads 0xFFFFFFFF when no fast source is pending.
- R9: The normal request output is high exactly while some source qualifies under R6. The fast request output is high exactly while some fast source is pending. Register writes take effect at the clock edge that samples them.
- R10: Control (0x00) is a 32-bit read/write register. Writes to unmapped offsets change nothing, and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 7 | Byte offset of the register |
| bus_we | input | 1 | Write strobe, sampled at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| src_in | input | 64 | Level-sensitive source inputs, bit N is source N |
| irq_norm_o | output | 1 | Normal interrupt request, active high |
| irq_fast_o | output | 1 | Fast interrupt request, active high |

## Verification
A wrong enable, type, force or priority bit changes the request outputs in the same cycle that the matching source input is presented. The bench compares those outputs with its model on every clock, so such an error shows up as soon as the bench presents that source pattern. It does not wait for a later readback. Arbitration errors show up on the vector registers: a wrong tie break or a wrong threshold comparison returns a different source number or priority in the read data. Corruption caused by writes by number, such as a neighbouring bit flipped, shows up on the next readback of the enable words.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int DATA_W  = 32;
  localparam int NSRC    = 2 * DATA_W;
  localparam int NUM_W   = $clog2(NSRC);
  localparam int PRIO_W  = 4;
  localparam int MASK_W  = PRIO_W + 1;
  localparam int PER_REG = DATA_W / PRIO_W;
  localparam int GROUPS  = NSRC / PER_REG;
  localparam int ADDR_W  = 7;
  localparam int HALF_W  = DATA_W / 2;

  localparam logic [ADDR_W-1:0] A_CTRL   = 7'h00;
  localparam logic [ADDR_W-1:0] A_MASK   = 7'h04;
  localparam logic [ADDR_W-1:0] A_ENNUM  = 7'h08;
  localparam logic [ADDR_W-1:0] A_DISNUM = 7'h0C;
  localparam logic [ADDR_W-1:0] A_EN_H   = 7'h10;
  localparam logic [ADDR_W-1:0] A_EN_L   = 7'h14;
  localparam logic [ADDR_W-1:0] A_TY_H   = 7'h18;
  localparam logic [ADDR_W-1:0] A_TY_L   = 7'h1C;
  localparam logic [ADDR_W-1:0] A_PRIO0  = 7'h20;
  localparam logic [ADDR_W-1:0] A_NVEC   = 7'h40;
  localparam logic [ADDR_W-1:0] A_FVEC   = 7'h44;
  localparam logic [ADDR_W-1:0] A_RAW_H  = 7'h48;
  localparam logic [ADDR_W-1:0] A_RAW_L  = 7'h4C;
  localparam logic [ADDR_W-1:0] A_FO_H   = 7'h50;
  localparam logic [ADDR_W-1:0] A_FO_L   = 7'h54;
  localparam logic [ADDR_W-1:0] A_PN_H   = 7'h58;
  localparam logic [ADDR_W-1:0] A_PN_L   = 7'h5C;
  localparam logic [ADDR_W-1:0] A_PF_H   = 7'h60;
  localparam logic [ADDR_W-1:0] A_PF_L   = 7'h64;

  // Priority word of group g: groups are laid out highest-first.
  function automatic logic [ADDR_W-1:0] prio_addr(input int g);
    return A_PRIO0 + ADDR_W'(4 * (GROUPS - 1 - g));
  endfunction

  // Threshold test for a normal source against the mask register.
  function automatic logic prio_passes(input logic [PRIO_W-1:0] p,
                                       input logic [MASK_W-1:0] m);
    return !m[PRIO_W] && (p >= m[PRIO_W-1:0]);
  endfunction

  // Vector word: number in the upper half, priority in the lower half.
  function automatic logic [DATA_W-1:0] pack_vec(input logic found,
                                                 input logic [NUM_W-1:0] num,
                                                 input logic [PRIO_W-1:0] p);
    if (!found) return '1;
    return {{(HALF_W-NUM_W){1'b0}}, num, {(HALF_W-PRIO_W){1'b0}}, p};
  endfunction
endpackage

// File: rtl/intc_regs.sv
module intc_regs
  import intc_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic                     bus_we,
  input  logic [DATA_W-1:0]        bus_wdata,
  output logic [DATA_W-1:0]        ctrl_q,
  output logic [MASK_W-1:0]        mask_q,
  output logic [NSRC-1:0]          en_q,
  output logic [NSRC-1:0]          type_q,
  output logic [NSRC-1:0]          force_q,
  output logic [NSRC*PRIO_W-1:0]   prio_flat
);
  logic              num_ok;
  logic [NUM_W-1:0]  num_sel;
  logic              set_ev;
  logic              clr_ev;

  assign num_ok  = (bus_wdata[DATA_W-1:NUM_W] == '0);
  assign num_sel = bus_wdata[NUM_W-1:0];
  assign set_ev  = bus_we && (bus_addr == A_ENNUM) && num_ok;
  assign clr_ev  = bus_we && (bus_addr == A_DISNUM) && num_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      mask_q    <= '1;
      en_q      <= '0;
      type_q    <= '0;
      force_q   <= '0;
      prio_flat <= '0;
    end else if (bus_we) begin
      case (bus_addr)
        A_CTRL:  ctrl_q <= bus_wdata;
        A_MASK:  mask_q <= bus_wdata[MASK_W-1:0];
        A_EN_H:  en_q[NSRC-1:DATA_W] <= bus_wdata;
        A_EN_L:  en_q[DATA_W-1:0] <= bus_wdata;
        A_TY_H:  type_q[NSRC-1:DATA_W] <= bus_wdata;
        A_TY_L:  type_q[DATA_W-1:0] <= bus_wdata;
        A_FO_H:  force_q[NSRC-1:DATA_W] <= bus_wdata;
        A_FO_L:  force_q[DATA_W-1:0] <= bus_wdata;
        default: ;
      endcase
      if (set_ev) en_q[num_sel] <= 1'b1;
      if (clr_ev) en_q[num_sel] <= 1'b0;
      for (int g = 0; g < GROUPS; g++) begin
        if (bus_addr == prio_addr(g))
          prio_flat[g*DATA_W +: DATA_W] <= bus_wdata;
      end
    end
  end

  // R2: set by number touches exactly one bit
  assert_en_set_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
    set_ev |=> en_q == ($past(en_q) | (NSRC'(1) << $past(num_sel))));
  // R2: clear by number touches exactly one bit
  assert_en_clr_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
    clr_ev |=> en_q == ($past(en_q) & ~(NSRC'(1) << $past(num_sel))));
  // R2: out-of-range number leaves enables alone
  assert_en_bad_num_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !num_ok && (bus_addr == A_ENNUM || bus_addr == A_DISNUM)) |=> $stable(en_q));
endmodule

// File: rtl/intc_norm_arb.sv
module intc_norm_arb
  import intc_pkg::*;
(
  input  logic [NSRC-1:0]         pend_n,
  input  logic [NSRC*PRIO_W-1:0]  prio_flat,
  input  logic [MASK_W-1:0]       mask_q,
  output logic                    found,
  output logic [NUM_W-1:0]        win_num,
  output logic [PRIO_W-1:0]       win_prio
);
  logic [PRIO_W-1:0] cand_p;

  // Ascending scan with >= lets a later (higher) number win a tie.
  always_comb begin
    found    = 1'b0;
    win_num  = '0;
    win_prio = '0;
    cand_p   = '0;
    for (int i = 0; i < NSRC; i++) begin
      cand_p = prio_flat[i*PRIO_W +: PRIO_W];
      if (pend_n[i] && prio_passes(cand_p, mask_q) &&
          (!found || cand_p >= win_prio)) begin
        found    = 1'b1;
        win_num  = NUM_W'(i);
        win_prio = cand_p;
      end
    end
  end
endmodule

// File: rtl/intc_fast_pick.sv
module intc_fast_pick
  import intc_pkg::*;
(
  input  logic [NSRC-1:0]  pend_f,
  output logic             found,
  output logic [NUM_W-1:0] win_num
);
  always_comb begin
    found   = 1'b0;
    win_num = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (pend_f[i]) begin
        found   = 1'b1;
        win_num = NUM_W'(i);
      end
    end
  end
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import intc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [6:0]        bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [63:0]       src_in,
  output logic              irq_norm_o,
  output logic              irq_fast_o
);
  logic [DATA_W-1:0]       ctrl_q;
  logic [MASK_W-1:0]       mask_q;
  logic [NSRC-1:0]         en_q, type_q, force_q;
  logic [NSRC*PRIO_W-1:0]  prio_flat;
  logic [NSRC-1:0]         eff, pend_n, pend_f;
  logic                    n_found, f_found;
  logic [NUM_W-1:0]        n_num, f_num;
  logic [PRIO_W-1:0]       n_prio;
  logic [DATA_W-1:0]       nvec, fvec;

  intc_regs u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .ctrl_q(ctrl_q), .mask_q(mask_q), .en_q(en_q),
    .type_q(type_q), .force_q(force_q), .prio_flat(prio_flat)
  );

  assign eff    = src_in | force_q;
  assign pend_n = eff & en_q & ~type_q;
  assign pend_f = eff & en_q & type_q;

  intc_norm_arb u_narb (
    .pend_n(pend_n), .prio_flat(prio_flat), .mask_q(mask_q),
    .found(n_found), .win_num(n_num), .win_prio(n_prio)
  );

  intc_fast_pick u_fpick (
    .pend_f(pend_f), .found(f_found), .win_num(f_num)
  );

  assign nvec       = pack_vec(n_found, n_num, n_prio);
  assign fvec       = pack_vec(f_found, f_num, '0);
  assign irq_norm_o = n_found;
  assign irq_fast_o = |pend_f;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL:  bus_rdata = ctrl_q;
      A_MASK:  bus_rdata = DATA_W'(mask_q);
      A_EN_H:  bus_rdata = en_q[NSRC-1:DATA_W];
      A_EN_L:  bus_rdata = en_q[DATA_W-1:0];
      A_TY_H:  bus_rdata = type_q[NSRC-1:DATA_W];
      A_TY_L:  bus_rdata = type_q[DATA_W-1:0];
      A_NVEC:  bus_rdata = nvec;
      A_FVEC:  bus_rdata = fvec;
      A_RAW_H: bus_rdata = src_in[NSRC-1:DATA_W];
      A_RAW_L: bus_rdata = src_in[DATA_W-1:0];
      A_FO_H:  bus_rdata = force_q[NSRC-1:DATA_W];
      A_FO_L:  bus_rdata = force_q[DATA_W-1:0];
      A_PN_H:  bus_rdata = pend_n[NSRC-1:DATA_W];
      A_PN_L:  bus_rdata = pend_n[DATA_W-1:0];
      A_PF_H:  bus_rdata = pend_f[NSRC-1:DATA_W];
      A_PF_L:  bus_rdata = pend_f[DATA_W-1:0];
      default: ;
    endcase
    for (int g = 0; g < GROUPS; g++) begin
      if (bus_addr == prio_addr(g)) bus_rdata = prio_flat[g*DATA_W +: DATA_W];
    end
  end

  // R6: global block bit silences the normal line
  assert_mask_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mask_q[PRIO_W] |-> !irq_norm_o);
  // R7: normal winner is pending and clears the threshold
  assert_norm_win_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_norm_o |-> (pend_n[n_num] && n_prio >= mask_q[PRIO_W-1:0]));
  // R7: reported priority is the winner's own field
  assert_norm_prio_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_norm_o |-> (prio_flat[n_num*PRIO_W +: PRIO_W] == n_prio));
  // R8: fast winner is the top pending bit
  assert_fast_top_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_fast_o |-> ((pend_f >> f_num) == NSRC'(1)));
  // R9: normal line only with some normal source pending
  assert_norm_needs_pend_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_norm_o |-> (pend_n != '0));
endmodule

// File: tb/sim_prio_intc.sv
module sim_prio_intc;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [63:0] src_in = '0;
  logic        irq_norm_o, irq_fast_o;

  int checks = 0;
  int fails = 0;
  bit running = 0;
  bit done = 0;

  // reference model state
  logic [63:0] m_en = '0, m_ty = '0, m_fo = '0;
  logic [3:0]  m_pr [64];
  logic [4:0]  m_mask = 5'h1F;
  logic [31:0] m_ctrl = '0;

  prio_intc u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_in(src_in),
    .irq_norm_o(irq_norm_o), .irq_fast_o(irq_fast_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit m_qual(input int n);
    logic [63:0] pn;
    pn = (src_in | m_fo) & m_en & ~m_ty;
    return pn[n] && !m_mask[4] && (m_pr[n] >= m_mask[3:0]);
  endfunction

  // scan priorities downwards, then numbers downwards
  function automatic logic [31:0] m_nvec();
    for (int p = 15; p >= 0; p--)
      for (int n = 63; n >= 0; n--)
        if (m_qual(n) && m_pr[n] == 4'(p))
          return {16'(n), 16'(p)};
    return 32'hFFFF_FFFF;
  endfunction

  function automatic logic [31:0] m_fvec();
    logic [63:0] pf;
    pf = (src_in | m_fo) & m_en & m_ty;
    for (int n = 63; n >= 0; n--)
      if (pf[n]) return {16'(n), 16'h0};
    return 32'hFFFF_FFFF;
  endfunction

  function automatic logic [31:0] m_read(input logic [6:0] a);
    logic [63:0] pn, pf;
    logic [31:0] w;
    int g;
    pn = (src_in | m_fo) & m_en & ~m_ty;
    pf = (src_in | m_fo) & m_en & m_ty;
    if (a >= 7'h20 && a <= 7'h3C && a[1:0] == 2'b00) begin
      g = 7 - ((int'(a) - 32) / 4);
      w = '0;
      for (int k = 0; k < 8; k++) w[k*4 +: 4] = m_pr[g*8 + k];
      return w;
    end
    case (a)
      7'h00: return m_ctrl;
      7'h04: return {27'h0, m_mask};
      7'h10: return m_en[63:32];
      7'h14: return m_en[31:0];
      7'h18: return m_ty[63:32];
      7'h1C: return m_ty[31:0];
      7'h40: return m_nvec();
      7'h44: return m_fvec();
      7'h48: return src_in[63:32];
      7'h4C: return src_in[31:0];
      7'h50: return m_fo[63:32];
      7'h54: return m_fo[31:0];
      7'h58: return pn[63:32];
      7'h5C: return pn[31:0];
      7'h60: return pf[63:32];
      7'h64: return pf[31:0];
      default: return 32'h0;
    endcase
  endfunction

  task automatic m_write(input logic [6:0] a, input logic [31:0] d);
    int g;
    if (a >= 7'h20 && a <= 7'h3C && a[1:0] == 2'b00) begin
      g = 7 - ((int'(a) - 32) / 4);
      for (int k = 0; k < 8; k++) m_pr[g*8 + k] = d[k*4 +: 4];
    end
    case (a)
      7'h00: m_ctrl = d;
      7'h04: m_mask = d[4:0];
      7'h08: if (d < 64) m_en[d[5:0]] = 1'b1;
      7'h0C: if (d < 64) m_en[d[5:0]] = 1'b0;
      7'h10: m_en[63:32] = d;
      7'h14: m_en[31:0] = d;
      7'h18: m_ty[63:32] = d;
      7'h1C: m_ty[31:0] = d;
      7'h50: m_fo[63:32] = d;
      7'h54: m_fo[31:0] = d;
      default: ;
    endcase
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_we = 1'b0;
    m_write(a, d);
  endtask

  task automatic set_src(input logic [63:0] v);
    @(posedge clk); #1;
    src_in = v;
  endtask

  task automatic rd_lit(input logic [6:0] a, input logic [31:0] exp, input string req);
    @(posedge clk); #1;
    bus_addr = a; #2;
    chk(req, bus_rdata, exp);
  endtask

  task automatic rd_model(input logic [6:0] a, input string req);
    @(posedge clk); #1;
    bus_addr = a; #2;
    chk(req, bus_rdata, m_read(a));
  endtask

  // R9: request outputs compared with the model on every clock
  always @(negedge clk) begin
    if (rst_n && running && !done) begin
      chk("R9 irq_norm_o", {31'h0, irq_norm_o}, {31'h0, m_nvec() != 32'hFFFF_FFFF});
      chk("R9 irq_fast_o", {31'h0, irq_fast_o}, {31'h0, m_fvec() != 32'hFFFF_FFFF});
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [6:0] rd_list [26];
    logic [6:0] wr_list [18];
    for (int i = 0; i < 64; i++) m_pr[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    running = 1;

    // R1 reset state
    rd_lit(7'h00, 32'h0, "R1 ctrl");
    rd_lit(7'h04, 32'h1F, "R1 mask");
    rd_lit(7'h10, 32'h0, "R1 en_h");
    rd_lit(7'h1C, 32'h0, "R1 type_l");
    rd_lit(7'h2C, 32'h0, "R1 prio");
    rd_lit(7'h40, 32'hFFFF_FFFF, "R1 nvec");
    rd_lit(7'h44, 32'hFFFF_FFFF, "R1 fvec");
    chk("R1 irq_norm", {31'h0, irq_norm_o}, 32'h0);

    // R2 enable and disable by number
    wr(7'h08, 32'd5);
    rd_lit(7'h14, 32'h0000_0020, "R2 set 5");
    wr(7'h08, 32'd40);
    rd_lit(7'h10, 32'h0000_0100, "R2 set 40");
    wr(7'h0C, 32'd5);
    rd_lit(7'h14, 32'h0, "R2 clear 5");
    rd_lit(7'h10, 32'h0000_0100, "R2 clear keeps 40");
    wr(7'h08, 32'h45);
    wr(7'h0C, 32'h68);
    rd_lit(7'h14, 32'h0, "R2 bad number low");
    rd_lit(7'h10, 32'h0000_0100, "R2 bad number high");
    rd_lit(7'h08, 32'h0, "R2 write-only read");

    // R3 direct bit registers
    wr(7'h50, 32'hA5A5_0000);
    rd_lit(7'h50, 32'hA5A5_0000, "R3 force_h");
    wr(7'h50, 32'h0);
    wr(7'h18, 32'h1234_5678);
    rd_lit(7'h18, 32'h1234_5678, "R3 type_h");
    wr(7'h18, 32'h0);

    // R4 priority layout: group 7 at 0x20, group 0 at 0x3C
    wr(7'h20, 32'h7654_3210);
    wr(7'h3C, 32'h0000_00A0);
    rd_lit(7'h20, 32'h7654_3210, "R4 group7");
    rd_lit(7'h3C, 32'h0000_00A0, "R4 group0");

    // R5/R7 pending and vector: src1 prio A, src60 prio 4, src61 prio 5
    wr(7'h04, 32'h0);
    wr(7'h14, 32'h0000_0002);
    wr(7'h10, 32'h3000_0000);
    set_src(64'h3000_0000_0000_0002);
    rd_lit(7'h5C, 32'h0000_0002, "R5 pend_n low");
    rd_lit(7'h58, 32'h3000_0000, "R5 pend_n high");
    rd_lit(7'h4C, 32'h0000_0002, "R5 raw low");
    rd_lit(7'h40, 32'h0001_000A, "R7 highest prio");
    // tie: src61 also prio A -> higher number wins
    wr(7'h20, 32'h76A4_3210);
    rd_lit(7'h40, 32'h003D_000A, "R7 tie higher number");

    // R6 masking
    wr(7'h04, 32'hFFFF_FF0B);
    rd_lit(7'h04, 32'h0000_000B, "R6 mask width");
    rd_lit(7'h40, 32'hFFFF_FFFF, "R6 threshold blocks");
    chk("R6 irq blocked", {31'h0, irq_norm_o}, 32'h0);
    wr(7'h04, 32'h0A);
    rd_lit(7'h40, 32'h003D_000A, "R6 threshold equal passes");
    wr(7'h04, 32'h10);
    rd_lit(7'h40, 32'hFFFF_FFFF, "R6 global block");
    wr(7'h04, 32'h00);

    // R8 fast routing of src61
    wr(7'h18, 32'h2000_0000);
    rd_lit(7'h44, 32'h003D_0000, "R8 fast vector");
    rd_lit(7'h60, 32'h2000_0000, "R8 fast pending");
    rd_lit(7'h40, 32'h0001_000A, "R8 normal after reroute");
    chk("R8 irq_fast", {31'h0, irq_fast_o}, 32'h1);

    // R5 force with inputs idle
    set_src(64'h0);
    wr(7'h18, 32'h0);
    rd_lit(7'h40, 32'hFFFF_FFFF, "R5 no input");
    wr(7'h54, 32'h0000_0002);
    rd_lit(7'h5C, 32'h0000_0002, "R5 force pending");
    rd_lit(7'h40, 32'h0001_000A, "R5 force vector");
    wr(7'h54, 32'h0);

    // R10 control and unmapped offsets
    wr(7'h00, 32'hDEAD_BEEF);
    rd_lit(7'h00, 32'hDEAD_BEEF, "R10 ctrl");
    wr(7'h68, 32'hFFFF_FFFF);
    rd_lit(7'h68, 32'h0, "R10 unmapped");
    rd_lit(7'h14, 32'h0000_0002, "R10 unmapped write harmless");

    // random phase compared against the model
    rd_list = '{7'h00,7'h04,7'h10,7'h14,7'h18,7'h1C,7'h20,7'h24,7'h28,7'h2C,
                7'h30,7'h34,7'h38,7'h3C,7'h40,7'h44,7'h48,7'h4C,7'h50,7'h54,
                7'h58,7'h5C,7'h60,7'h64,7'h08,7'h6C};
    wr_list = '{7'h04,7'h08,7'h0C,7'h10,7'h14,7'h18,7'h1C,7'h20,7'h24,7'h28,
                7'h2C,7'h30,7'h34,7'h38,7'h3C,7'h50,7'h54,7'h08};
    for (int it = 0; it < 400; it++) begin
      logic [6:0]  a;
      logic [31:0] d;
      a = wr_list[$urandom % 18];
      d = $urandom;
      if (a == 7'h08 || a == 7'h0C) d = $urandom % 80;
      if (a == 7'h04) d = $urandom % 40;
      if (a == 7'h50 || a == 7'h54) d = d & $urandom & $urandom;
      wr(a, d);
      if (it % 3 == 0) set_src({$urandom, $urandom} & {$urandom, $urandom});
      rd_model(7'h40, "R7 random nvec");
      rd_model(7'h44, "R8 random fvec");
      rd_model(rd_list[$urandom % 26], "R5 random read");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule